// File: doc/BRIEF.md
# Multiplexed ADC scan sequencer

The sequencer walks four differential inputs that share a single delta-sigma converter. For each input it puts the channel number on a two-line select bus. It then either sends the converter a one-cycle resynchronisation pulse (sync mode) or lets a settle timer run (timed mode). Once the input has settled it captures complete serial words from the converter and reports each one with its channel number.

Serial words come in on a bit clock, a data line and an active-low frame line. All three pass through two-flop synchronisers into the system clock domain. Bits are taken MSB first on each rising bit clock while the frame is low, and a word is complete when the frame rises. A start pulse given while idle runs one scan: channels 0, 1, 2, 3, with `WORDS_PER_CH` results per channel. The block then goes idle until the next start.

Top module: `adc_scan_seq`

## Requirements
- R1: While rst_ni is low, chan_sel_o is 0, sync_o is low and res_valid_o is low.
- R2: start_i sampled high in idle begins a scan at channel 0. chan_sel_o carries the channel in binary, bit 0 on the A line and bit 1 on the B line. The select steps 0, 1, 2, 3 after every `WORDS_PER_CH` reported words. After channel 3 the block returns to idle. start_i is ignored during a scan. res_ch_o carries the channel whose select was applied when the word arrived.
- R3: In sync mode, sync_o is high for exactly the one cycle that follows each clock edge that loads a new select value. In timed mode sync_o stays low.
- R4: Bits are shifted in MSB first on each synchronised rising bit-clock edge while frame_ni is low. If frame_ni rises between clock edges k and k+1, a reported word appears on res_data_o with res_valid_o high for one cycle, between edges k+4 and k+5.
- R5: A word whose frame_ni falling edge comes before the clock edge that loads a new select value is discarded. This includes a word still being shifted out when sync is raised. In sync mode, later words are reported without any cycle count.
- R6: In timed mode, a word is reported only if its result edge lies at least `SETTLE_CYC` clock cycles after the edge that loaded the select. Earlier words are dropped.
- R7: After settling, `WORDS_PER_CH` consecutive words on one channel are reported with the select held unchanged, so each scan yields 4 x `WORDS_PER_CH` results.
- R8: sync_mode_i (1 = sync, 0 = timed) is sampled only when a scan starts. Changes during a scan have no effect.
- R9: Words that complete while the block is idle are not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts one scan when idle |
| sync_mode_i | input | 1 | 1 = sync settling, 0 = timed settling |
| chan_sel_o | output | 2 | Channel select lines (bit 0 = A, bit 1 = B) |
| sync_o | output | 1 | Converter resynchronisation pulse |
| sclk_i | input | 1 | Converter bit clock |
| sdata_i | input | 1 | Converter serial data |
| frame_ni | input | 1 | Converter frame, low while a word is shifted |
| res_data_o | output | DATA_W | Captured word |
| res_ch_o | output | 2 | Channel tag of the captured word |
| res_valid_o | output | 1 | One-cycle strobe when the result is written |

## Verification
A result strobe is due exactly four clock cycles after the converter model raises the frame. The bench queues each expected word with that due cycle and checks, on every falling clock edge, that the strobe is present in that cycle and absent in all others. The new select value is due in the cycle the previous channel's last result appears, or one cycle after the start is driven. The sync pulse is due in that same first cycle. Both are predicted and compared every cycle. Whether a word counts is decided from its frame-fall cycle relative to the select change, and in timed mode from its due cycle minus the change cycle.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SWITCH,
    ST_GUARD,
    ST_WAIT
  } scan_state_e;
endpackage

// File: rtl/adc_sync_edge.sv
module adc_sync_edge #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] ff1_q, ff2_q, prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff1_q[i]  <= 1'b1;
        ff2_q[i]  <= 1'b1;
        prev_q[i] <= 1'b1;
      end else begin
        ff1_q[i]  <= async_i[i];
        ff2_q[i]  <= ff1_q[i];
        prev_q[i] <= ff2_q[i];
      end
    end
    assign rise_o[i] = ff2_q[i] & ~prev_q[i];
    assign fall_o[i] = ~ff2_q[i] & prev_q[i];
  end

  assign level_o = ff2_q;
endmodule

// File: rtl/adc_word_rx.sv
module adc_word_rx #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_rise_i,
  input  logic              sdata_i,
  input  logic              frame_low_i,
  input  logic              frame_fall_i,
  input  logic              frame_rise_i,
  input  logic              flush_i,
  output logic              done_o,
  output logic              clean_o,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] shift_q;
  logic              taint_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      taint_q <= 1'b1;
      done_o  <= 1'b0;
      clean_o <= 1'b0;
      data_o  <= '0;
    end else begin
      if (sclk_rise_i && frame_low_i) shift_q <= {shift_q[DATA_W-2:0], sdata_i};
      // flush wins: a word already started when the select moves stays tainted
      if (flush_i)           taint_q <= 1'b1;
      else if (frame_fall_i) taint_q <= 1'b0;
      done_o <= frame_rise_i;
      if (frame_rise_i) begin
        data_o  <= shift_q;
        clean_o <= ~taint_q;
      end
    end
  end
endmodule

// File: rtl/adc_settle_tmr.sv
module adc_settle_tmr #(
  parameter int SETTLE_CYC = 4740
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic elapsed_o
);
  localparam int CNT_W = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clear_i)       cnt_q <= '0;
    else if (cnt_q < LIMIT) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign elapsed_o = (cnt_q >= LIMIT);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int NUM_CH       = 4,
  parameter int WORDS_PER_CH = 2,
  parameter int SETTLE_CYC   = 4740,
  localparam int CH_W        = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sync_mode_i,
  output logic [CH_W-1:0]   chan_sel_o,
  output logic              sync_o,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              frame_ni,
  output logic [DATA_W-1:0] res_data_o,
  output logic [CH_W-1:0]   res_ch_o,
  output logic              res_valid_o
);
  localparam int WC_W = (WORDS_PER_CH > 1) ? $clog2(WORDS_PER_CH) : 1;
  localparam logic [CH_W-1:0] LAST_CH   = CH_W'(NUM_CH - 1);
  localparam logic [WC_W-1:0] LAST_WORD = WC_W'(WORDS_PER_CH - 1);
  localparam int FR = 2, SC = 1, SD = 0;

  scan_state_e     state_q;
  logic [CH_W-1:0] ch_q;
  logic [WC_W-1:0] wcnt_q;
  logic            mode_q;

  logic [2:0] lvl, rise, fall;
  logic       edge_unused;
  logic       rx_done, rx_clean, settled;
  logic [DATA_W-1:0] rx_data;
  logic       accept, last_word, load_sel, flush;

  adc_sync_edge #(.N(3)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({frame_ni, sclk_i, sdata_i}),
    .level_o (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );
  assign edge_unused = ^{rise[SD], fall[SD], fall[SC]};

  adc_word_rx #(.DATA_W(DATA_W)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sclk_rise_i  (rise[SC]),
    .sdata_i      (lvl[SD]),
    .frame_low_i  (~lvl[FR]),
    .frame_fall_i (fall[FR]),
    .frame_rise_i (rise[FR]),
    .flush_i      (flush),
    .done_o       (rx_done),
    .clean_o      (rx_clean),
    .data_o       (rx_data)
  );

  adc_settle_tmr #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (load_sel),
    .elapsed_o (settled)
  );

  assign accept    = (state_q == ST_WAIT) && rx_done && rx_clean && (mode_q || settled);
  assign last_word = (wcnt_q == LAST_WORD);
  assign load_sel  = ((state_q == ST_IDLE) && start_i) ||
                     (accept && last_word && (ch_q != LAST_CH));
  // guard state covers the synchroniser delay on the frame line
  assign flush     = load_sel || (state_q == ST_SWITCH) || (state_q == ST_GUARD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      wcnt_q  <= '0;
      mode_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q  <= sync_mode_i;
          ch_q    <= '0;
          wcnt_q  <= '0;
          state_q <= ST_SWITCH;
        end
        ST_SWITCH: state_q <= ST_GUARD;
        ST_GUARD:  state_q <= ST_WAIT;
        ST_WAIT: if (accept) begin
          if (!last_word) begin
            wcnt_q <= wcnt_q + WC_W'(1);
          end else begin
            wcnt_q <= '0;
            if (ch_q == LAST_CH) begin
              state_q <= ST_IDLE;
            end else begin
              ch_q    <= ch_q + CH_W'(1);
              state_q <= ST_SWITCH;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_data_o  <= '0;
      res_ch_o    <= '0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= accept;
      if (accept) begin
        res_data_o <= rx_data;
        res_ch_o   <= ch_q;
      end
    end
  end

  assign chan_sel_o = ch_q;
  assign sync_o     = (state_q == ST_SWITCH) && mode_q;

  // R3
  sync_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);
  // R4
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
  // R2
  res_ch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> (res_ch_o == $past(chan_sel_o)));
  // R7
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && $past(state_q) == ST_WAIT) |-> $stable(chan_sel_o));
  // R6
  timed_settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !mode_q) |-> $past(settled));
endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  localparam int DW = 16, NCH = 4, WPC = 2, SETTLE = 400;
  localparam int SYNC_WAIT = 450, BH = 3, GAP = 2, LAT = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, frame_n = 1'b1;
  logic [1:0] sel, res_ch;
  logic sync, res_valid;
  logic [DW-1:0] res_data;

  adc_scan_seq #(.DATA_W(DW), .NUM_CH(NCH), .WORDS_PER_CH(WPC), .SETTLE_CYC(SETTLE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sync_mode_i(mode),
    .chan_sel_o(sel), .sync_o(sync), .sclk_i(sclk), .sdata_i(sdata), .frame_ni(frame_n),
    .res_data_o(res_data), .res_ch_o(res_ch), .res_valid_o(res_valid)
  );

  always #4 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0, res_count = 0;
  bit rst_done = 0;
  string cur_tag = "R9";

  // reference model state
  bit m_active = 0, m_sync = 0;
  int m_ch = 0, m_cnt = 0, m_ssw = 0;
  int sel_prev = 0, sel_next = 0, sel_chg = 0, sync_exp = -1;
  int q_due[$], q_ch[$];
  logic [DW-1:0] q_dat[$];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
    end
  endtask

  initial forever @(posedge clk) cyc++;

  // per-cycle comparison against the model
  initial forever @(negedge clk) begin
    if (rst_done) begin
      int exp_sel;
      exp_sel = (cyc >= sel_chg) ? sel_next : sel_prev;
      chk(sel == 2'(exp_sel), "R2", "select", sel, exp_sel);
      chk(sync == (cyc == sync_exp), "R3", "sync", sync, cyc == sync_exp);
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        chk(res_valid, "R4", "strobe missing", res_valid, 1);
        chk(res_data == q_dat[0], "R4", "data", res_data, q_dat[0]);
        chk(res_ch == 2'(q_ch[0]), "R2", "channel tag", res_ch, q_ch[0]);
        void'(q_due.pop_front()); void'(q_dat.pop_front()); void'(q_ch.pop_front());
        res_count++;
      end else begin
        chk(!res_valid, cur_tag, "unexpected strobe", res_valid, 0);
      end
    end
  end

  function automatic void model_word(input int m, input int n, input logic [DW-1:0] d);
    int due;
    due = n + LAT;
    if (m_active && m >= m_ssw && (m_sync || (due - m_ssw >= SETTLE))) begin
      q_due.push_back(due); q_dat.push_back(d); q_ch.push_back(m_ch);
      m_cnt++;
      if (m_cnt == WPC) begin
        m_cnt = 0;
        if (m_ch == NCH - 1) m_active = 0;
        else begin
          m_ch++;
          m_ssw = due;
          sel_prev = sel_next; sel_next = m_ch; sel_chg = due;
          sync_exp = m_sync ? due : -1;
        end
      end
    end
  endfunction

  // converter model
  int wait_until = 0, gap_until = 0, word_idx = 0;

  task automatic tick();
    @(negedge clk);
    if (sync) wait_until = cyc + SYNC_WAIT;
  endtask

  task automatic emit_word();
    int m, n;
    logic [DW-1:0] d;
    d = DW'(word_idx * 16'h3B1D) ^ 16'hC35A;
    word_idx++;
    m = cyc;
    frame_n = 1'b0;
    for (int i = 0; i < DW; i++) begin
      sdata = d[DW-1-i];
      repeat (BH) tick();
      sclk = 1'b1;
      repeat (BH) tick();
      sclk = 1'b0;
    end
    repeat (BH) tick();
    frame_n = 1'b1;
    n = cyc;
    model_word(m, n, d);
    gap_until = cyc + GAP;
  endtask

  initial begin
    wait (rst_done);
    forever begin
      @(negedge clk);
      if (sync) wait_until = cyc + SYNC_WAIT;
      if (cyc >= wait_until && cyc >= gap_until) emit_word();
    end
  end

  task automatic run_scan(input bit smode, input string tag, input bit disturb);
    int t;
    cur_tag = tag;
    res_count = 0;
    @(negedge clk);
    mode = smode; start = 1'b1;
    m_active = 1; m_sync = smode; m_ch = 0; m_cnt = 0; m_ssw = cyc + 1;
    sel_prev = sel_next; sel_next = 0; sel_chg = cyc + 1;
    sync_exp = smode ? cyc + 1 : -1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (30) @(negedge clk);
      mode = ~smode; start = 1'b1;   // R8 and R2: both must be ignored mid-scan
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while ((m_active || q_due.size() > 0) && t < 30000) begin
      @(negedge clk);
      t++;
    end
    repeat (20) @(negedge clk);
    chk(q_due.size() == 0, "R4", "pending results", q_due.size(), 0);
    chk(res_count == NCH * WPC, "R7", "results per scan", res_count, NCH * WPC);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1
    chk(sel == 2'd0, "R1", "select in reset", sel, 0);
    chk(!sync, "R1", "sync in reset", sync, 0);
    chk(!res_valid, "R1", "valid in reset", res_valid, 0);
    rst_n = 1'b1;
    rst_done = 1;
    repeat (300) @(negedge clk);   // R9: idle, converter running
    run_scan(1'b1, "R5", 1'b0);
    run_scan(1'b0, "R6", 1'b0);
    run_scan(1'b1, "R8", 1'b1);
    run_scan(1'b0, "R8", 1'b1);
    cur_tag = "R9";
    repeat (300) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule